// File: doc/BRIEF.md
# Partition power-up sequencer

This block brings one power-gated partition out of power-down by driving the partition's reset, clock enable, power request and clamp-release lines directly. A single start pulse runs the whole ordered sequence. The partition is held in reset and its clock is stopped before power is requested. Once power-good is reported, the clock is turned back on. After a fixed settle time the isolation clamps are released, and finally reset is let go. Every wait on the partition is bounded. A wait that runs out of time triggers an ordered rollback, and the shape of that rollback depends on how far the sequence had got.

All timing is expressed in microseconds. A prescaler, configured with the number of clock cycles per microsecond, turns these into cycles. The prescaler and the microsecond counter restart on every state change, so each wait has an exact length in cycles. The block reports its state with a busy level and with single-cycle done and error pulses. If the partition already reports power-good when start arrives, the request is acknowledged at once and nothing is done.

Top module: `partition_wake_seq`

## Requirements
- R1: After reset the outputs are: partition reset asserted (1), clock enable 0, power request 0, clamp release 0, busy 0, done 0, error 0.
- R2: A start sampled while idle with power-good low first asserts reset, then stops the clock on the next edge, then raises the power request on the edge after that. The power request is therefore visible in the third cycle after the start edge, and at that moment reset is high and the clock enable is low.
- R3: The clock enable rises on the first edge at which power-good is sampled high, provided this happens within POLL_MAX*CYC_PER_US+1 cycles of the power request becoming visible.
- R4: Clamp release rises exactly SETTLE_US*CYC_PER_US+1 cycles after the clock enable rises. Clamp release is only ever high while power request, clock enable and reset are all high.
- R5: If power-good is not seen within the R3 window, the rollback leaves the clock enable untouched (it stays 0) and keeps reset asserted. The power request drops POLL_MAX*CYC_PER_US+2 cycles after it became visible.
- R6: If the clamp status is still high POLL_MAX*CYC_PER_US+1 cycles after clamp release became visible, the clock enable and clamp release drop together first, reset is asserted on the next edge, and the power request drops on the edge after that.
- R7: After the power request drops during a rollback, the error pulse follows on the edge at which power-good is sampled low, or after POLL_MAX*CYC_PER_US+1 cycles if that comes first. At the error pulse the outputs are in the safe state: reset 1, clock enable 0, power request 0, clamp release 0.
- R8: On success, done pulses on the edge at which the clamp status is sampled low (within POLL_MAX*CYC_PER_US+1 cycles of clamp release becoming visible). Reset deasserts and clamp release drops on that same edge, while clock enable and power request stay high.
- R9: A start sampled while idle with power-good already high produces a done pulse on that edge, changes no partition control, and never raises busy.
- R10: A start pulse arriving while busy is ignored: the timing of the running sequence is unchanged and exactly one done or error pulse results.
- R11: Busy is high from the edge that accepts a start until the edge that issues done or error, and is low again in the cycle that shows that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to power the partition up (pulse) |
| pwr_good_i | input | 1 | Partition reports its rail powered |
| clamped_i | input | 1 | Partition isolation clamps are engaged |
| part_rst_o | output | 1 | Partition reset, 1 = held in reset |
| part_clk_en_o | output | 1 | Partition clock enable |
| pwr_req_o | output | 1 | Request power for the partition |
| clamp_rel_o | output | 1 | Request release of the isolation clamps |
| busy_o | output | 1 | Sequence or rollback in progress |
| done_o | output | 1 | One-cycle pulse: partition is up |
| err_o | output | 1 | One-cycle pulse: sequence failed and was rolled back |

## Verification
The bench uses a small configuration and models the partition as a delay line. It sweeps the power-good response delay over every value from one cycle to one past the poll bound, so the last value that still succeeds and the first that times out are both observed. It then does the same for the clamp-release delay, which separates the success path from the rollback that disables the clock first. Further runs vary how fast power-good falls after removal (immediately, at the bound, past it, never) to exercise both exits of the power-off wait. They also cover the rollback from a power timeout, which must leave the clock alone. Two more cases drive a start into a running sequence and a start to an already powered partition, checking that neither the timing nor the controls move.

// File: rtl/pws_pkg.sv
package pws_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ISOLATE,
      ST_CLK_STOP,
      ST_PWR_WAIT,
      ST_SETTLE,
      ST_CLAMP_WAIT,
      RB_CLK_STOP,
      RB_ISOLATE,
      RB_PWR_DROP
   } pws_state_e;

   typedef struct packed {
      logic hold_rst;
      logic clk_on;
      logic pwr_on;
      logic clamp_rel;
   } pws_ctl_t;

   localparam pws_ctl_t PWS_CTL_SAFE = '{hold_rst: 1'b1, clk_on: 1'b0,
                                         pwr_on: 1'b0, clamp_rel: 1'b0};

endpackage

// File: rtl/pws_prescale.sv
module pws_prescale #(
   parameter int CYC_PER_US = 100
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   output logic tick_o
);
   localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;

   if (CYC_PER_US < 1) begin : g_bad_rate
      $error("pws_prescale: CYC_PER_US must be at least 1");
   end

   if (CYC_PER_US == 1) begin : g_direct
      assign tick_o = !clr_i;
   end else begin : g_count
      logic [PW-1:0] cnt_q;
      logic          wrap;

      assign wrap   = (cnt_q == PW'(CYC_PER_US - 1));
      assign tick_o = wrap && !clr_i;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)          cnt_q <= '0;
         else if (clr_i||wrap) cnt_q <= '0;
         else                  cnt_q <= cnt_q + 1'b1;
      end

      AST_PRESCALE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         int'(cnt_q) < CYC_PER_US); // R4
   end

endmodule

// File: rtl/pws_step_timer.sv
module pws_step_timer #(
   parameter int US_W = 8
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            clr_i,
   input  logic            tick_i,
   input  logic [US_W-1:0] limit_i,
   output logic            expired_o
);
   logic [US_W-1:0] us_q;

   if (US_W < 1) begin : g_bad_width
      $error("pws_step_timer: US_W must be at least 1");
   end

   assign expired_o = (us_q == limit_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    us_q <= '0;
      else if (clr_i)                 us_q <= '0;
      else if (tick_i && !expired_o)  us_q <= us_q + 1'b1;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (us_q <= limit_i) || $changed(limit_i)); // R3

endmodule

// File: rtl/partition_wake_seq.sv
module partition_wake_seq
   import pws_pkg::*;
#(
   parameter int CYC_PER_US = 100,
   parameter int POLL_MAX   = 100,
   parameter int SETTLE_US  = 20
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic pwr_good_i,
   input  logic clamped_i,
   output logic part_rst_o,
   output logic part_clk_en_o,
   output logic pwr_req_o,
   output logic clamp_rel_o,
   output logic busy_o,
   output logic done_o,
   output logic err_o
);
   localparam int US_MAX = (POLL_MAX > SETTLE_US) ? POLL_MAX : SETTLE_US;
   localparam int US_W   = $clog2(US_MAX + 1);

   if (POLL_MAX < 1) begin : g_bad_poll
      $error("partition_wake_seq: POLL_MAX must be at least 1");
   end
   if (SETTLE_US < 1) begin : g_bad_settle
      $error("partition_wake_seq: SETTLE_US must be at least 1");
   end

   pws_state_e      st_q, st_d;
   pws_ctl_t        ctl_q, ctl_d;
   logic            done_d, err_d, done_q, err_q;
   logic            tmr_clr, us_tick, expired;
   logic [US_W-1:0] lim;

   assign tmr_clr = (st_d != st_q);
   assign lim     = (st_q == ST_SETTLE) ? US_W'(SETTLE_US) : US_W'(POLL_MAX);

   pws_prescale #(.CYC_PER_US(CYC_PER_US)) i_prescale (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (tmr_clr),
      .tick_o (us_tick)
   );

   pws_step_timer #(.US_W(US_W)) i_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (tmr_clr),
      .tick_i    (us_tick),
      .limit_i   (lim),
      .expired_o (expired)
   );

   // next state and completion flags
   always_comb begin
      st_d   = st_q;
      done_d = 1'b0;
      err_d  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               if (pwr_good_i) done_d = 1'b1;
               else            st_d   = ST_ISOLATE;
            end
         end
         ST_ISOLATE:  st_d = ST_CLK_STOP;
         ST_CLK_STOP: st_d = ST_PWR_WAIT;
         ST_PWR_WAIT: begin
            if (pwr_good_i)   st_d = ST_SETTLE;
            else if (expired) st_d = RB_ISOLATE;
         end
         ST_SETTLE: begin
            if (expired) st_d = ST_CLAMP_WAIT;
         end
         ST_CLAMP_WAIT: begin
            if (!clamped_i) begin
               st_d   = ST_IDLE;
               done_d = 1'b1;
            end else if (expired) begin
               st_d = RB_CLK_STOP;
            end
         end
         RB_CLK_STOP: st_d = RB_ISOLATE;
         RB_ISOLATE:  st_d = RB_PWR_DROP;
         RB_PWR_DROP: begin
            if (!pwr_good_i || expired) begin
               st_d  = ST_IDLE;
               err_d = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   // partition controls change only when a state is entered
   always_comb begin
      ctl_d = ctl_q;
      if (tmr_clr) begin
         unique case (st_d)
            ST_ISOLATE:    ctl_d.hold_rst  = 1'b1;
            ST_CLK_STOP:   ctl_d.clk_on    = 1'b0;
            ST_PWR_WAIT:   ctl_d.pwr_on    = 1'b1;
            ST_SETTLE:     ctl_d.clk_on    = 1'b1;
            ST_CLAMP_WAIT: ctl_d.clamp_rel = 1'b1;
            RB_CLK_STOP: begin
               ctl_d.clk_on    = 1'b0;
               ctl_d.clamp_rel = 1'b0;
            end
            RB_ISOLATE: begin
               ctl_d.hold_rst  = 1'b1;
               ctl_d.clamp_rel = 1'b0;
            end
            RB_PWR_DROP:   ctl_d.pwr_on    = 1'b0;
            ST_IDLE: begin
               if (done_d) begin
                  ctl_d.hold_rst  = 1'b0;
                  ctl_d.clamp_rel = 1'b0;
               end
            end
            default: ctl_d = ctl_q;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         ctl_q  <= PWS_CTL_SAFE;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         ctl_q  <= ctl_d;
         done_q <= done_d;
         err_q  <= err_d;
      end
   end

   assign part_rst_o    = ctl_q.hold_rst;
   assign part_clk_en_o = ctl_q.clk_on;
   assign pwr_req_o     = ctl_q.pwr_on;
   assign clamp_rel_o   = ctl_q.clamp_rel;
   assign busy_o        = (st_q != ST_IDLE);
   assign done_o        = done_q;
   assign err_o         = err_q;

   AST_PWR_AFTER_ISOLATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwr_req_o) |-> part_rst_o && !part_clk_en_o); // R2
   AST_CLAMP_NEEDS_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clamp_rel_o |-> pwr_req_o && part_clk_en_o && part_rst_o); // R4
   AST_PWR_DROP_CLK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pwr_req_o) |-> part_rst_o && !part_clk_en_o && !clamp_rel_o); // R6
   AST_ERR_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> part_rst_o && !part_clk_en_o && !pwr_req_o && !clamp_rel_o); // R7
   AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(done_o && err_o)); // R7
   AST_RST_RELEASE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(part_rst_o) |-> done_o && pwr_req_o && part_clk_en_o); // R8
   AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> done_o || err_o); // R11

endmodule

// File: tb/test_partition_wake_seq.sv
module test_partition_wake_seq;
   localparam int CLK_PERIOD = 10;
   localparam int C     = 3;
   localparam int P     = 5;
   localparam int L     = 4;
   localparam int W     = P * C + 1;
   localparam int ST    = L * C + 1;
   localparam int NEVER = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic pwr_good = 1'b0;
   logic clamped = 1'b1;
   logic part_rst, clk_en, pwr_req, clamp_rel, busy, done, err;

   int nchk = 0, nerr = 0, cyc = 0;
   int d_on = NEVER, d_cl = NEVER, d_off = NEVER;
   int on_cnt = 0, off_cnt = 0, cl_cnt = 0;
   int t_pwr_rise, t_pwr_fall, t_clk_rise, t_clk_fall, t_clamp_rise, t_clamp_fall;
   int t_rst_fall, t_done, t_err, t_busy_rise, t_busy_fall, n_done, n_err;
   int rst_at_pwr, clk_at_pwr;
   logic p_clk = 1'b0, p_pwr = 1'b0, p_clamp = 1'b0, p_rst = 1'b1, p_busy = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   partition_wake_seq #(.CYC_PER_US(C), .POLL_MAX(P), .SETTLE_US(L)) i_partition_wake_seq (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pwr_good_i(pwr_good),
      .clamped_i(clamped), .part_rst_o(part_rst), .part_clk_en_o(clk_en),
      .pwr_req_o(pwr_req), .clamp_rel_o(clamp_rel), .busy_o(busy),
      .done_o(done), .err_o(err)
   );

   // partition model and event recorder, at the falling edge
   always @(negedge clk) begin
      cyc = cyc + 1;
      if (!rst_n) begin
         on_cnt = 0; off_cnt = 0; cl_cnt = 0;
         pwr_good = 1'b0; clamped = 1'b1;
      end else begin
         if (pwr_req) begin
            on_cnt = on_cnt + 1; off_cnt = 0;
            if (on_cnt == d_on) pwr_good = 1'b1;
         end else begin
            off_cnt = off_cnt + 1; on_cnt = 0;
            if (off_cnt == d_off) pwr_good = 1'b0;
         end
         if (clamp_rel) begin
            cl_cnt = cl_cnt + 1;
            if (cl_cnt == d_cl) clamped = 1'b0;
         end else cl_cnt = 0;
         if (!pwr_good) clamped = 1'b1;
      end
      if (pwr_req && !p_pwr && t_pwr_rise < 0) begin
         t_pwr_rise = cyc; rst_at_pwr = int'(part_rst); clk_at_pwr = int'(clk_en);
      end
      if (!pwr_req && p_pwr && t_pwr_fall < 0) t_pwr_fall = cyc;
      if (clk_en && !p_clk && t_clk_rise < 0) t_clk_rise = cyc;
      if (!clk_en && p_clk && t_clk_fall < 0) t_clk_fall = cyc;
      if (clamp_rel && !p_clamp && t_clamp_rise < 0) t_clamp_rise = cyc;
      if (!clamp_rel && p_clamp && t_clamp_fall < 0) t_clamp_fall = cyc;
      if (!part_rst && p_rst && t_rst_fall < 0) t_rst_fall = cyc;
      if (busy && !p_busy && t_busy_rise < 0) t_busy_rise = cyc;
      if (!busy && p_busy && t_busy_fall < 0) t_busy_fall = cyc;
      if (done) begin n_done = n_done + 1; if (t_done < 0) t_done = cyc; end
      if (err)  begin n_err = n_err + 1;   if (t_err < 0)  t_err = cyc;  end
      p_pwr = pwr_req; p_clk = clk_en; p_clamp = clamp_rel; p_rst = part_rst; p_busy = busy;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_events();
      t_pwr_rise = -1; t_pwr_fall = -1; t_clk_rise = -1; t_clk_fall = -1;
      t_clamp_rise = -1; t_clamp_fall = -1; t_rst_fall = -1; t_done = -1;
      t_err = -1; t_busy_rise = -1; t_busy_fall = -1; n_done = 0; n_err = 0;
      rst_at_pwr = -1; clk_at_pwr = -1;
   endtask

   task automatic do_reset();
      @(negedge clk); #1; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      #1; rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   function automatic int min2(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   task automatic run_seq(input int on_d, input int cl_d, input int off_d, input bit poke);
      int s, e, fin;
      d_on = on_d; d_cl = cl_d; d_off = off_d;
      do_reset();
      clear_events();
      @(negedge clk); #1; start = 1'b1; s = cyc;
      @(negedge clk); #1; start = 1'b0;
      if (poke) begin
         repeat (4) @(negedge clk);
         #1; start = 1'b1;                     // R10: start while busy
         @(negedge clk); #1; start = 1'b0;
      end
      for (int i = 0; i < 600 && (n_done + n_err) == 0; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      #1;
      chk("R2", "power request rise", t_pwr_rise, s + 3);
      chk("R2", "reset at power rise", rst_at_pwr, 1);
      chk("R2", "clock at power rise", clk_at_pwr, 0);
      chk("R10", "single completion", n_done + n_err, 1);
      chk("R11", "busy rise", t_busy_rise, s + 1);
      if (on_d <= W) begin
         chk("R3", "clock re-enable", t_clk_rise, s + 3 + on_d);
         chk("R4", "clamp release rise", t_clamp_rise, s + 3 + on_d + ST);
         if (cl_d <= W) begin
            fin = t_clamp_rise + cl_d;
            chk("R8", "done time", t_done, fin);
            chk("R8", "reset release", t_rst_fall, fin);
            chk("R8", "clamp release drop", t_clamp_fall, fin);
            chk("R8", "clock on at end", int'(clk_en), 1);
            chk("R8", "power on at end", int'(pwr_req), 1);
            chk("R8", "no error", n_err, 0);
         end else begin
            chk("R6", "clock off on clamp timeout", t_clk_fall, t_clamp_rise + W);
            chk("R6", "clamp drop with clock", t_clamp_fall, t_clamp_rise + W);
            chk("R6", "power drop order", t_pwr_fall, t_clamp_rise + W + 2);
            fin = t_pwr_fall + min2(off_d, W);
            chk("R7", "error time", t_err, fin);
         end
      end else begin
         chk("R5", "clock untouched", t_clk_rise, -1);
         chk("R5", "power drop on timeout", t_pwr_fall, s + W + 4);
         e = (on_d <= P * C + 2) ? off_d : 1;
         fin = t_pwr_fall + min2(e, W);
         chk("R7", "error time", t_err, fin);
      end
      if (n_err > 0) begin
         chk("R7", "safe reset", int'(part_rst), 1);
         chk("R7", "safe clock", int'(clk_en), 0);
         chk("R7", "safe power", int'(pwr_req), 0);
         chk("R7", "no done", n_done, 0);
      end
      chk("R11", "busy fall", t_busy_fall, (n_err > 0) ? t_err : t_done);
   endtask

   initial begin
      clear_events();
      repeat (3) @(negedge clk);
      #1;
      chk("R1", "reset out", int'(part_rst), 1);
      chk("R1", "clock out", int'(clk_en), 0);
      chk("R1", "power out", int'(pwr_req), 0);
      chk("R1", "clamp out", int'(clamp_rel), 0);
      chk("R1", "busy out", int'(busy), 0);
      chk("R1", "pulses", int'(done) + int'(err), 0);
      rst_n = 1'b1;

      for (int on_d = 1; on_d <= W + 1; on_d++) run_seq(on_d, 2, 3, 1'b0);
      for (int cl_d = 1; cl_d <= W + 1; cl_d++) run_seq(2, cl_d, 3, 1'b0);
      run_seq(2, NEVER, 1, 1'b0);
      run_seq(2, NEVER, W, 1'b0);
      run_seq(2, NEVER, W + 1, 1'b0);
      run_seq(2, NEVER, NEVER, 1'b0);
      run_seq(NEVER, 2, 3, 1'b0);
      run_seq(3, 4, 3, 1'b1);

      // R9: partition already powered after the last successful run
      begin
         int s;
         clear_events();
         @(negedge clk); #1; start = 1'b1; s = cyc;
         @(negedge clk); #1; start = 1'b0;
         repeat (4) @(negedge clk);
         #1;
         chk("R9", "immediate done", t_done, s + 1);
         chk("R9", "busy never", t_busy_rise, -1);
         chk("R9", "reset unchanged", int'(part_rst), 0);
         chk("R9", "clock unchanged", int'(clk_en), 1);
         chk("R9", "power unchanged", int'(pwr_req), 1);
         chk("R9", "no power drop", t_pwr_fall, -1);
      end

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule